// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserve / Store-Conditional

This block keeps a single reservation for atomic read-modify-write sequences built from a load-and-reserve followed by a conditional store. Each request carries a base operand, an index operand and a flag that marks the base field as zero. The block forms the effective address from these operands. A reserve request remembers the word that contains that address. A conditional store checks whether its own word still matches the held reservation.

When the conditional store matches, the block issues a one-cycle write request with the full effective address and the store data. In every case it returns a 4-bit condition code that tells the core whether the store took place. The reservation is dropped by every conditional store, whether it succeeded or not, and by an explicit drop command. A separate valid flag marks the held reservation, so word zero can be reserved like any other word. The core pairs the block with a memory write port. That memory, cache coherence and snooping by other masters are handled elsewhere.

Top module: `lrsc_monitor`

## Requirements
- R1: After reset no write request and no result are driven, and no reservation is held, so a conditional store fails.
- R2: The effective address is base plus index (modulo 2^AW), or the index alone when `base_zero_i` is 1.
- R3: A reserve request (`op_kind_i` = 2'b01) records the effective address with its two low bits cleared, so a conditional store to any byte of that 4-byte word matches.
- R4: A conditional store (`op_kind_i` = 2'b10) raises `wr_valid_o` with `wr_addr_o` equal to its effective address and `wr_data_o` equal to `wdata_i` only when a reservation is held and its word equals the store's word. Otherwise it issues no write.
- R5: The condition code of a conditional store is 4'b0010 ORed with `ov_i` in bit 0 on success, and `ov_i` alone in bit 0 on failure. Bits 3:2 are always 0.
- R6: Every conditional store drops the reservation, whether it succeeded or failed, so a second conditional store fails until a new reserve request arrives.
- R7: A drop command (`op_kind_i` = 2'b11) removes the reservation and produces no result and no write.
- R8: Word address zero can be reserved, and a matching conditional store to it succeeds.
- R9: The result and the write request appear in the cycle after the request, as one-cycle pulses, and only for conditional stores. Reserve, drop and idle cycles (`op_valid_i` = 0 or kind 2'b00) produce no result.
- R10: A newer reserve request replaces the older reservation, so a conditional store to the older word then fails.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Request present this cycle |
| op_kind_i | input | 2 | 01 reserve, 10 conditional store, 11 drop, 00 none |
| base_i | input | AW | Base operand |
| index_i | input | AW | Index operand |
| base_zero_i | input | 1 | Base field is zero: use the index alone |
| wdata_i | input | DW | Data for the conditional store |
| ov_i | input | 1 | Overflow status bit folded into the code |
| wr_valid_o | output | 1 | One-cycle memory write request |
| wr_addr_o | output | AW | Write address |
| wr_data_o | output | DW | Write data |
| res_valid_o | output | 1 | Condition code is valid |
| res_code_o | output | 4 | Condition code of the conditional store |

## Verification
The hardest case to reach is a conditional store that hits the reservation through a different base and index split, or a different byte offset inside the reserved word. Uniform random operands almost never match. The stimulus therefore takes effective addresses from a small pool of words, including word zero, picks a random byte offset, and splits each address into a random base and index, or uses the index alone with the zero-base flag. Directed sequences cover the rest: a second conditional store right after the first, a drop between reserve and store, and a reserve that replaces an older one.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  typedef enum logic [1:0] {
    OP_IDLE    = 2'b00,
    OP_RESERVE = 2'b01,
    OP_STCOND  = 2'b10,
    OP_DROP    = 2'b11
  } lrsc_op_e;

  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] CODE_PASS = 4'b0010;
endpackage

// File: rtl/lrsc_ea_gen.sv
module lrsc_ea_gen #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] index_i,
  input  logic          base_zero_i,
  output logic [AW-1:0] ea_o
);
  always_comb begin
    if (base_zero_i) ea_o = index_i;
    else             ea_o = base_i + index_i;
  end
endmodule

// File: rtl/lrsc_rsv_track.sv
module lrsc_rsv_track #(
  parameter int AW   = 32,
  parameter int GRAN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_i,
  input  logic          drop_i,
  input  logic [AW-1:0] ea_i,
  output logic          hit_o,
  output logic          held_o
);
  localparam int TAG_W = AW - GRAN;

  logic             held_q, held_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic             tag_en;

  assign tag_en = set_i;

  always_comb begin
    held_d = held_q;
    if (drop_i)     held_d = 1'b0;
    else if (set_i) held_d = 1'b1;
    tag_d = ea_i[AW-1:GRAN];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      tag_q  <= '0;
    end else begin
      held_q <= held_d;
      if (tag_en) tag_q <= tag_d;
    end
  end

  assign hit_o  = held_q && (tag_q == ea_i[AW-1:GRAN]);
  assign held_o = held_q;

  // R3
  rsv_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !drop_i) |=> (held_q && tag_q == $past(ea_i[AW-1:GRAN])));
  // R6 R7
  rsv_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_i |=> !held_q);
  // R1
  rsv_nohold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !held_q |-> !hit_o);
endmodule

// File: rtl/lrsc_resp.sv
module lrsc_resp
  import lrsc_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stcond_i,
  input  logic              hit_i,
  input  logic              ov_i,
  input  logic [AW-1:0]     ea_i,
  input  logic [DW-1:0]     wdata_i,
  output logic              wr_valid_o,
  output logic [AW-1:0]     wr_addr_o,
  output logic [DW-1:0]     wr_data_o,
  output logic              res_valid_o,
  output logic [CODE_W-1:0] res_code_o
);
  logic              wr_valid_q, wr_valid_d;
  logic [AW-1:0]     wr_addr_q;
  logic [DW-1:0]     wr_data_q;
  logic              res_valid_q, res_valid_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              load_en;

  assign load_en = stcond_i;

  always_comb begin
    wr_valid_d  = stcond_i && hit_i;
    res_valid_d = stcond_i;
    code_d      = {{(CODE_W-1){1'b0}}, ov_i};
    if (hit_i) code_d = code_d | CODE_PASS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid_q  <= 1'b0;
      res_valid_q <= 1'b0;
      wr_addr_q   <= '0;
      wr_data_q   <= '0;
      code_q      <= '0;
    end else begin
      wr_valid_q  <= wr_valid_d;
      res_valid_q <= res_valid_d;
      if (load_en) begin
        wr_addr_q <= ea_i;
        wr_data_q <= wdata_i;
        code_q    <= code_d;
      end
    end
  end

  assign wr_valid_o  = wr_valid_q;
  assign wr_addr_o   = wr_addr_q;
  assign wr_data_o   = wr_data_q;
  assign res_valid_o = res_valid_q;
  assign res_code_o  = code_q;

  // R4
  write_has_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> (res_valid_o && res_code_o[1]));
  // R5
  code_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> (res_code_o[CODE_W-1:2] == '0));
  // R4
  fail_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_code_o[1]) |-> !wr_valid_o);
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
  import lrsc_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int GRAN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid_i,
  input  logic [1:0]    op_kind_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] index_i,
  input  logic          base_zero_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ov_i,
  output logic          wr_valid_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          res_valid_o,
  output logic [3:0]    res_code_o
);
  lrsc_op_e      kind;
  logic          do_reserve, do_stcond, do_drop;
  logic [AW-1:0] ea;
  logic          hit, held;

  assign kind       = lrsc_op_e'(op_kind_i);
  assign do_reserve = op_valid_i && (kind == OP_RESERVE);
  assign do_stcond  = op_valid_i && (kind == OP_STCOND);
  assign do_drop    = op_valid_i && ((kind == OP_DROP) || (kind == OP_STCOND));

  lrsc_ea_gen #(.AW(AW)) u_ea (
    .base_i      (base_i),
    .index_i     (index_i),
    .base_zero_i (base_zero_i),
    .ea_o        (ea)
  );

  lrsc_rsv_track #(.AW(AW), .GRAN(GRAN)) u_rsv (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (do_reserve),
    .drop_i (do_drop),
    .ea_i   (ea),
    .hit_o  (hit),
    .held_o (held)
  );

  lrsc_resp #(.AW(AW), .DW(DW)) u_resp (
    .clk         (clk),
    .rst_n       (rst_n),
    .stcond_i    (do_stcond),
    .hit_i       (hit),
    .ov_i        (ov_i),
    .ea_i        (ea),
    .wdata_i     (wdata_i),
    .wr_valid_o  (wr_valid_o),
    .wr_addr_o   (wr_addr_o),
    .wr_data_o   (wr_data_o),
    .res_valid_o (res_valid_o),
    .res_code_o  (res_code_o)
  );

  // R9
  result_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> $past(do_stcond));
  // R6
  no_back_to_back_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |=> !wr_valid_o);
  // R4
  hit_needs_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_stcond && !held) |=> !wr_valid_o);
endmodule

// File: tb/lrsc_monitor_tb.sv
`timescale 1ns/1ps
module lrsc_monitor_tb;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          op_valid;
  logic [1:0]    op_kind;
  logic [AW-1:0] base, index;
  logic          base_zero;
  logic [DW-1:0] wdata;
  logic          ov;
  logic          wr_valid, res_valid;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [3:0]    res_code;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  logic          m_held;
  logic [AW-3:0] m_tag;

  always #2 clk = ~clk;

  lrsc_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid), .op_kind_i(op_kind),
    .base_i(base), .index_i(index), .base_zero_i(base_zero), .wdata_i(wdata),
    .ov_i(ov), .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .res_valid_o(res_valid), .res_code_o(res_code)
  );

  function automatic logic [AW-1:0] calc_ea(input logic [AW-1:0] b, input logic [AW-1:0] i,
                                            input logic bz);
    return bz ? i : b + i;
  endfunction

  function automatic logic [69:0] pack_out(input logic rv, input logic [3:0] c, input logic wv,
                                           input logic [AW-1:0] a, input logic [DW-1:0] d);
    return {rv, c, wv, (wv ? a : '0), (wv ? d : '0)};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [69:0] act,
                       input logic [69:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] k, input logic [AW-1:0] b, input logic [AW-1:0] i,
                        input logic bz, input logic [DW-1:0] d, input logic o, input string tag);
    logic [AW-1:0] ea;
    logic          hit;
    logic [69:0]   exp, act;
    ea  = calc_ea(b, i, bz);
    hit = m_held && (m_tag == ea[AW-1:2]);
    op_valid = 1'b1; op_kind = k; base = b; index = i; base_zero = bz; wdata = d; ov = o;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    if (k == 2'b10) exp = pack_out(1'b1, {2'b00, hit, o}, hit, ea, d);
    else            exp = pack_out(1'b0, 4'b0000, 1'b0, '0, '0);
    act = pack_out(res_valid, (res_valid ? res_code : 4'b0000), wr_valid, wr_addr, wr_data);
    check(act == exp, tag, act, exp);
    if (k == 2'b01) begin m_held = 1'b1; m_tag = ea[AW-1:2]; end
    else if (k == 2'b10 || k == 2'b11) m_held = 1'b0;
  endtask

  task automatic idle_check(input string tag);
    logic [69:0] act;
    @(posedge clk);
    @(negedge clk);
    act = pack_out(res_valid, res_code, wr_valid, wr_addr, wr_data);
    check(!res_valid && !wr_valid, tag, act, '0);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] pool [4];
    void'($urandom(32'h5eed_1234));
    m_held = 1'b0; m_tag = '0;
    op_valid = 1'b0; op_kind = 2'b00; base = '0; index = '0; base_zero = 1'b0;
    wdata = '0; ov = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!res_valid && !wr_valid, "R1 reset outputs",
          pack_out(res_valid, res_code, wr_valid, wr_addr, wr_data), '0);
    rst_n = 1'b1;
    @(negedge clk);
    run_op(2'b10, 32'h100, 32'h4, 1'b0, 32'hAAAA_0001, 1'b0, "R1 store after reset fails");
    // R8 R2 reserve word zero using base_zero
    run_op(2'b01, 32'hFFFF_0000, 32'h0, 1'b1, '0, 1'b0, "R8 reserve zero");
    run_op(2'b10, 32'h0, 32'h3, 1'b1, 32'hCAFE_0000, 1'b0, "R8 store to word zero");
    // R6 second store fails
    run_op(2'b10, 32'h0, 32'h0, 1'b1, 32'h1, 1'b0, "R6 second store fails");
    // R3 R2 same word, other offset, other split; R5 with ov
    run_op(2'b01, 32'h1000, 32'h0235, 1'b0, '0, 1'b0, "R3 reserve");
    run_op(2'b10, 32'h1200, 32'h0034, 1'b0, 32'h1357_9BDF, 1'b1, "R5 pass with ov");
    // R5 fail with ov
    run_op(2'b10, 32'h1200, 32'h0034, 1'b0, 32'h2, 1'b1, "R5 fail with ov");
    // R7 drop
    run_op(2'b01, 32'h40, 32'h8, 1'b0, '0, 1'b0, "R7 reserve");
    run_op(2'b11, 32'h0, 32'h0, 1'b0, '0, 1'b0, "R7 drop no result");
    run_op(2'b10, 32'h40, 32'h8, 1'b0, 32'h3, 1'b0, "R7 store after drop fails");
    // R10 replacement
    run_op(2'b01, 32'h0, 32'h500, 1'b1, '0, 1'b0, "R10 reserve old");
    run_op(2'b01, 32'h0, 32'h900, 1'b1, '0, 1'b0, "R10 reserve new");
    run_op(2'b10, 32'h0, 32'h500, 1'b1, 32'h4, 1'b0, "R10 old word fails");
    // R2 wraparound sum
    run_op(2'b01, 32'hFFFF_FFF0, 32'h20, 1'b0, '0, 1'b0, "R2 reserve wrap");
    run_op(2'b10, 32'h0, 32'h11, 1'b1, 32'h5, 1'b0, "R2 store wrap");
    // R9 pulses, idle kinds
    run_op(2'b01, 32'h0, 32'h80, 1'b1, '0, 1'b0, "R9 reserve");
    run_op(2'b10, 32'h0, 32'h80, 1'b1, 32'h6, 1'b0, "R9 store");
    idle_check("R9 pulse ends");
    run_op(2'b00, 32'h0, 32'h80, 1'b1, 32'h7, 1'b0, "R9 kind none");

    pool[0] = 32'h0; pool[1] = 32'h4; pool[2] = 32'h8000_0000; pool[3] = 32'hFFFF_FFFC;
    for (int n = 0; n < 400; n++) begin
      logic [1:0]    k;
      logic [AW-1:0] ea, b;
      logic          bz;
      int            r;
      r  = $urandom_range(0, 9);
      k  = (r < 4) ? 2'b01 : (r < 8) ? 2'b10 : (r == 8) ? 2'b11 : 2'b00;
      ea = pool[$urandom_range(0, 3)] + 32'($urandom_range(0, 3));
      bz = ($urandom_range(0, 3) == 0);
      b  = $urandom;
      run_op(k, b, bz ? ea : ea - b, bz, $urandom, 1'($urandom_range(0, 1)),
             "R4 random mix");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule